// File: doc/BRIEF.md
# Table-Driven Automaton Stream Engine

This block steps a deterministic finite automaton over a stream of character-class indices, one symbol per clock. The automaton has no hard-coded transition logic: every next state is read from a transition table held in an on-chip RAM. The table is addressed by the incoming class index joined above the current state. A registered RAM read supplies the next state directly, so the engine keeps pace with the input stream.

The RAM is dual-ported. The engine reads through one port and a loader writes through the other. Swapping in a different automaton only means rewriting the table, the per-state accept bitmap and the start-state register, all through one loader interface. Loader writes are honoured only while the engine is halted. A write attempted while the engine is running is dropped and reported on an error output.

Top module: `dfa_table_engine`

## Requirements
- R1: While `rst_n` is low, `state` is 0, `accept` is 0 and `ld_err` is 0. The accept bitmap and the start-state register also reset to all zeros.
- R2: When `run_en` and `sym_valid` are both high and `start` is low at a clock edge, `state` after that edge equals the table entry at address `{sym_cls, state}`. The class index fills the upper `CLS_W` bits and the state fills the lower `ST_W` bits.
- R3: When `start` is low and either `run_en` or `sym_valid` is low at an edge, `state` keeps its value.
- R4: When `start` is high at an edge, `state` after that edge equals the start-state register value from before that edge. No symbol is consumed in that cycle, even if one is presented.
- R5: `accept` equals the bit of the accept bitmap indexed by the present `state`, in the same cycle.
- R6: A loader write (`ld_we` high) selects its target with `ld_kind`. Kind 0 writes `ld_data` into table entry `ld_addr`. Kind 1 sets accept bit `ld_addr[ST_W-1:0]` to `ld_data[0]`. Kind 2 sets the start-state register to `ld_data`. Kind 3 changes nothing.
- R7: A loader write made while `run_en` is high changes neither the table, the accept bitmap nor the start state. `ld_err` is high in the cycle after such a write and low after any cycle without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Engine running; blocks loader writes |
| start | input | 1 | Force the state to the start-state register |
| sym_valid | input | 1 | `sym_cls` carries a symbol |
| sym_cls | input | CLS_W | Character-class index of the symbol |
| ld_we | input | 1 | Loader write strobe |
| ld_kind | input | 2 | Loader target: 0 table, 1 accept bit, 2 start state, 3 none |
| ld_addr | input | CLS_W+ST_W | Table address, or state index in its low bits |
| ld_data | input | ST_W | Next-state value, accept bit in bit 0, or start state |
| state | output | ST_W | Current automaton state |
| accept | output | 1 | Current state is accepting |
| ld_err | output | 1 | Previous cycle held a loader write made while running |

## Verification
The bench loads several random tables and runs long random class streams against a reference array model. It checks the state and accept flag every cycle, so a design that swaps the class and state halves of the address, or reads one cycle late, diverges within a few symbols. Directed cases drive a start pulse together with a valid symbol, which catches a design that lets the symbol win. They also issue loader writes while running; a design that lets these through corrupts a later start or accept result, and a missing or sticky error flag is caught directly. Kind-3 writes are followed by a full stream, so a design that writes on that kind shows a wrong state later.

// File: rtl/dfa_table_engine.sv
module dfa_table_engine #(
  parameter int ST_W  = 4,
  parameter int CLS_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  run_en,
  input  logic                  start,
  input  logic                  sym_valid,
  input  logic [CLS_W-1:0]      sym_cls,
  input  logic                  ld_we,
  input  logic [1:0]            ld_kind,
  input  logic [CLS_W+ST_W-1:0] ld_addr,
  input  logic [ST_W-1:0]       ld_data,
  output logic [ST_W-1:0]       state,
  output logic                  accept,
  output logic                  ld_err
);
  localparam int AW     = CLS_W + ST_W;
  localparam int DEPTH  = 1 << AW;
  localparam int NSTATE = 1 << ST_W;

  logic [ST_W-1:0]   tbl [DEPTH];
  logic [NSTATE-1:0] acc_q;
  logic [ST_W-1:0]   start_q;

  wire consume = run_en && sym_valid && !start;
  wire ld_ok   = ld_we && !run_en;

  // loader port
  always_ff @(posedge clk)
    if (ld_ok && ld_kind == 2'd0) tbl[ld_addr] <= ld_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      acc_q   <= '0;
      start_q <= '0;
      ld_err  <= 1'b0;
    end else begin
      ld_err <= ld_we && run_en;
      if (ld_ok && ld_kind == 2'd1) acc_q[ld_addr[ST_W-1:0]] <= ld_data[0];
      if (ld_ok && ld_kind == 2'd2) start_q <= ld_data;
    end

  // engine port: registered read is the state
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        state <= '0;
    else if (start)    state <= start_q;
    else if (consume)  state <= tbl[{sym_cls, state}];

  assign accept = acc_q[state];

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !(run_en && sym_valid)) |=> $stable(state));

  a_r4_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> state == $past(start_q));

  a_r7_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_we && run_en) |=> ld_err);

  a_r7_err_clr: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_we && run_en) |=> !ld_err);

  a_r7_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> ($stable(start_q) && $stable(acc_q)));

  always_comb
    if (!rst_n) a_r1_reset: assert (state == '0 && !ld_err);
endmodule

// File: tb/dfa_table_engine_tb.sv
module dfa_table_engine_tb;
  localparam int SW = 4;
  localparam int CW = 6;
  localparam int AW = SW + CW;
  localparam int DEPTH = 1 << AW;
  localparam int NS = 1 << SW;

  logic clk = 0, rst_n = 0;
  logic run_en = 0, start = 0, sym_valid = 0, ld_we = 0;
  logic [CW-1:0] sym_cls = '0;
  logic [1:0] ld_kind = '0;
  logic [AW-1:0] ld_addr = '0;
  logic [SW-1:0] ld_data = '0;
  logic [SW-1:0] state;
  logic accept, ld_err;

  always #5 clk = ~clk;

  dfa_table_engine #(.ST_W(SW), .CLS_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .start(start),
    .sym_valid(sym_valid), .sym_cls(sym_cls), .ld_we(ld_we),
    .ld_kind(ld_kind), .ld_addr(ld_addr), .ld_data(ld_data),
    .state(state), .accept(accept), .ld_err(ld_err));

  logic [SW-1:0] m_tbl [DEPTH];
  logic [NS-1:0] m_acc = '0;
  logic [SW-1:0] m_start = '0, m_st = '0;
  logic m_err = 0;
  int checks = 0, fails = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit r, input bit s, input bit v, input logic [CW-1:0] c,
                      input bit we, input logic [1:0] k, input logic [AW-1:0] a,
                      input logic [SW-1:0] d, input string req);
    @(negedge clk);
    run_en = r; start = s; sym_valid = v; sym_cls = c;
    ld_we = we; ld_kind = k; ld_addr = a; ld_data = d;
    if (s) m_st = m_start;
    else if (r && v) m_st = m_tbl[{c, m_st}];
    m_err = we && r;
    if (we && !r) begin
      if (k == 2'd0) m_tbl[a] = d;
      else if (k == 2'd1) m_acc[a[SW-1:0]] = d[0];
      else if (k == 2'd2) m_start = d;
    end
    @(posedge clk); #1;
    chk(req, state, m_st);
    chk("R5", accept, m_acc[m_st]);
    chk("R7", ld_err, m_err);
  endtask

  task automatic load_random();
    for (int i = 0; i < DEPTH; i++)
      step(0, 0, 0, '0, 1, 2'd0, AW'(i), SW'($urandom), "R6");
    for (int i = 0; i < NS; i++)
      step(0, 0, 0, '0, 1, 2'd1, AW'(i), SW'($urandom % 2), "R6");
    step(0, 0, 0, '0, 1, 2'd2, '0, SW'($urandom), "R6");
  endtask

  task automatic stream(input int n);
    step(1, 1, 0, '0, 0, 2'd0, '0, '0, "R4");
    for (int i = 0; i < n; i++) begin
      bit v = ($urandom % 4) != 0;
      step(1, 0, v, CW'($urandom), 0, 2'd0, '0, '0, v ? "R2" : "R3");
    end
  endtask

  initial begin
    #200_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'hD15EA5E));
    #12;
    chk("R1", state, 0); chk("R1", accept, 0); chk("R1", ld_err, 0);
    @(negedge clk); rst_n = 1;
    for (int t = 0; t < 3; t++) begin
      load_random();
      stream(400);
      // R4: start with a valid symbol present does not consume it
      step(1, 1, 1, CW'($urandom), 0, 2'd0, '0, '0, "R4");
      // R3: running but nothing valid, then halted with valid
      step(1, 0, 0, CW'($urandom), 0, 2'd0, '0, '0, "R3");
      step(0, 0, 1, CW'($urandom), 0, 2'd0, '0, '0, "R3");
      // R7: writes while running are dropped
      step(1, 0, 0, '0, 1, 2'd2, '0, ~m_start, "R7");
      step(1, 0, 0, '0, 1, 2'd1, AW'(m_st), SW'(~m_acc[m_st]), "R7");
      step(1, 0, 0, '0, 1, 2'd0, {CW'(0), m_st}, ~m_tbl[{CW'(0), m_st}], "R7");
      step(1, 0, 1, '0, 0, 2'd0, '0, '0, "R7");
      step(1, 1, 0, '0, 0, 2'd0, '0, '0, "R7");
      // R6: kind 3 writes are ignored
      for (int i = 0; i < 32; i++)
        step(0, 0, 0, '0, 1, 2'd3, AW'($urandom), SW'($urandom), "R6");
      stream(200);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule